// File: doc/BRIEF.md
# Multithreaded Function Unit Issue Stage

This block is a single function unit shared by several hardware thread slots. Each slot holds one buffered operation. Every cycle the unit picks one buffered operation whose operands are available and sends it into the execute pipeline. The execute latency is a parameter. Results then reach a one-entry result register that requests a register-file write. When nothing is ready, a bubble (nop) enters the pipeline in place of an operation.

Threads are ranked by age, and slot 0 is the oldest, so a lower index always wins. A thread fetches its next operation only once its buffered one has issued. A fetch may happen in the same cycle as that issue, so one thread can issue on every cycle. A write that is not granted freezes the whole pipeline, and the result is held until a later grant. When a write is granted, it also counts as operand availability for the same thread in that cycle, so a dependent operation is not held back by a late scoreboard. A taken branch stops fetch for its own thread only, and fetch resumes when the branch resolution pulse arrives.

The operation word passes through the pipeline unchanged and appears as the write data. Its most significant bit marks a branch. The unit does not decode any other bits.

Top module: `mt_issue_unit`

## Requirements
- R1: While reset is held, and with all inputs low after it, `iss_vld_o`, `wr_req_o` and every bit of `op_take_o` are 0.
- R2: `op_take_o[t]` is 1 exactly when all of the following hold: slot t is active, `op_vld_i[t]` is 1, slot t is not waiting on a branch, and its buffer is either empty or issuing a non-branch operation this cycle. The taken word is held in the buffer from the next cycle.
- R3: A slot is ready when it is active, its buffer is full, its operand flag `opd_rdy_i[t]` is 1 (or R7 applies), and the unit is not stalled. The lowest-index ready slot issues. `iss_tag_o` is its index and `iss_op_o` is its buffered word.
- R4: If no slot is ready, `iss_vld_o` is 0. A bubble enters the pipeline, and the write stage is empty EXLAT+1 cycles later.
- R5: An operation that issues in cycle c appears on `wr_req_o`/`wr_tag_o`/`wr_data_o` in cycle c+EXLAT+1, provided no stall occurs in between. Its tag and word are unchanged.
- R6: While `wr_req_o` is 1 and `wr_gnt_i` is 0, nothing issues. The pipeline and the write outputs hold their values into the next cycle.
- R7: When `wr_req_o` and `wr_gnt_i` are both 1, the slot named by `wr_tag_o` counts as operand-ready in that same cycle.
- R8: When an operation with bit OPW-1 set issues from slot t, slot t takes no operation until a cycle after `br_done_i[t]` is 1. Other slots are not affected.
- R9: An inactive slot never issues or takes an operation. Its buffer and branch wait are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_act_i | input | NTHR | Slot active flags |
| op_vld_i | input | NTHR | Next operation available for each slot |
| op_i | input | NTHR*OPW | Next operation word for each slot (slot t at bits t*OPW upward) |
| opd_rdy_i | input | NTHR | Scoreboard: operands of buffered operation available |
| br_done_i | input | NTHR | Branch target known, one pulse per slot |
| wr_gnt_i | input | 1 | Register write granted this cycle |
| op_take_o | output | NTHR | Slot fetches its next operation this cycle |
| iss_vld_o | output | 1 | An operation issues this cycle |
| iss_tag_o | output | TW | Slot index of the issued operation |
| iss_op_o | output | OPW | Issued operation word |
| wr_req_o | output | 1 | Result register requests a write |
| wr_tag_o | output | TW | Slot owning the result |
| wr_data_o | output | OPW | Result word |

## Verification
The bench targets three kinds of bug.

- Priority: several slots become ready together. A reversed or rotating priority would put the wrong tag on the issue port.
- Grant and stall: long runs of refused grants, and grants that arrive with a bypass-only ready slot. A unit that issues during a stall would lose or reorder results. A unit that ignores the forwarded grant would issue a bubble where the slot should go.
- Slot control: branches that resolve in the very next cycle or much later, and slots dropped while they hold a buffered operation or a branch wait. A leaked wait would fetch too early or never again, and a stale buffer would issue after deactivation.

// File: rtl/mt_issue_unit.sv
module mt_issue_unit #(
  parameter int NTHR  = 4,
  parameter int OPW   = 16,
  parameter int EXLAT = 2,
  localparam int TW   = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NTHR-1:0]     thr_act_i,
  input  logic [NTHR-1:0]     op_vld_i,
  input  logic [NTHR*OPW-1:0] op_i,
  input  logic [NTHR-1:0]     opd_rdy_i,
  input  logic [NTHR-1:0]     br_done_i,
  input  logic                wr_gnt_i,
  output logic [NTHR-1:0]     op_take_o,
  output logic                iss_vld_o,
  output logic [TW-1:0]       iss_tag_o,
  output logic [OPW-1:0]      iss_op_o,
  output logic                wr_req_o,
  output logic [TW-1:0]       wr_tag_o,
  output logic [OPW-1:0]      wr_data_o
);

  logic [NTHR-1:0] bufv, bw, rdy;
  logic [OPW-1:0]  bufd [NTHR];
  logic            exv  [EXLAT];
  logic [TW-1:0]   ext  [EXLAT];
  logic [OPW-1:0]  exd  [EXLAT];
  logic            wbv;
  logic [TW-1:0]   wbt;
  logic [OPW-1:0]  wbd;
  logic [TW-1:0]   sel;
  logic            stall, wr_ok;

  assign stall     = wbv & ~wr_gnt_i;
  assign wr_ok     = wbv & wr_gnt_i;
  assign wr_req_o  = wbv;
  assign wr_tag_o  = wbt;
  assign wr_data_o = wbd;

  always_comb begin
    sel = '0;
    for (int i = NTHR-1; i >= 0; i--)
      if (rdy[i]) sel = TW'(i);
  end

  assign iss_vld_o = |rdy;
  assign iss_tag_o = sel;
  assign iss_op_o  = iss_vld_o ? bufd[sel] : '0;

  for (genvar t = 0; t < NTHR; t++) begin : g_slot
    logic fwd, go;
    assign fwd    = wr_ok & (wbt == TW'(t));
    assign rdy[t] = thr_act_i[t] & bufv[t] & (opd_rdy_i[t] | fwd) & ~stall;
    assign go     = iss_vld_o & (sel == TW'(t));
    assign op_take_o[t] = thr_act_i[t] & op_vld_i[t] & ~bw[t] &
                          (~bufv[t] | (go & ~bufd[t][OPW-1]));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bufv[t] <= 1'b0;
        bw[t]   <= 1'b0;
        bufd[t] <= '0;
      end else if (!thr_act_i[t]) begin
        bufv[t] <= 1'b0;
        bw[t]   <= 1'b0;
      end else begin
        if (op_take_o[t]) begin
          bufv[t] <= 1'b1;
          bufd[t] <= op_i[t*OPW +: OPW];
        end else if (go) begin
          bufv[t] <= 1'b0;
        end
        if (go && bufd[t][OPW-1]) bw[t] <= 1'b1;
        else if (br_done_i[t])    bw[t] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < EXLAT; i++) begin
        exv[i] <= 1'b0;
        ext[i] <= '0;
        exd[i] <= '0;
      end
      wbv <= 1'b0;
      wbt <= '0;
      wbd <= '0;
    end else if (!stall) begin
      exv[0] <= iss_vld_o;
      ext[0] <= iss_tag_o;
      exd[0] <= iss_op_o;
      for (int i = 1; i < EXLAT; i++) begin
        exv[i] <= exv[i-1];
        ext[i] <= ext[i-1];
        exd[i] <= exd[i-1];
      end
      wbv <= exv[EXLAT-1];
      wbt <= ext[EXLAT-1];
      wbd <= exd[EXLAT-1];
    end
  end

endmodule

// File: rtl/mt_issue_unit_chk.sv
module mt_issue_unit_chk #(
  parameter int NTHR = 4,
  parameter int OPW  = 16,
  parameter int TW   = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NTHR-1:0] thr_act_i,
  input logic [NTHR-1:0] opd_rdy_i,
  input logic            wr_gnt_i,
  input logic [NTHR-1:0] op_take_o,
  input logic            iss_vld_o,
  input logic [TW-1:0]   iss_tag_o,
  input logic [OPW-1:0]  iss_op_o,
  input logic            wr_req_o,
  input logic [TW-1:0]   wr_tag_o,
  input logic [OPW-1:0]  wr_data_o
);

  AST_STALL_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_o && !wr_gnt_i) |-> !iss_vld_o); // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_o && !wr_gnt_i) |=> (wr_req_o && $stable(wr_tag_o) && $stable(wr_data_o))); // R6
  AST_ISSUE_OPND: assert property (@(posedge clk) disable iff (!rst_n)
    iss_vld_o |-> (opd_rdy_i[iss_tag_o] || (wr_req_o && wr_gnt_i && wr_tag_o == iss_tag_o))); // R7
  AST_ISSUE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    iss_vld_o |-> thr_act_i[iss_tag_o]); // R9
  AST_IDLE_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_take_o & ~thr_act_i) == '0); // R9
  AST_BRANCH_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_vld_o && iss_op_o[OPW-1]) |=> !op_take_o[$past(iss_tag_o)]); // R8

endmodule

bind mt_issue_unit mt_issue_unit_chk #(.NTHR(NTHR), .OPW(OPW), .TW(TW)) u_chk (.*);

// File: tb/mt_issue_unit_test.sv
module mt_issue_unit_test;
  localparam int NTHR = 4, OPW = 16, EXLAT = 2, TW = 2, NCYC = 4000;

  logic clk = 0, rst_n = 0, wr_gnt_i = 0;
  logic [NTHR-1:0] thr_act_i = 0, op_vld_i = 0, opd_rdy_i = 0, br_done_i = 0;
  logic [NTHR*OPW-1:0] op_i = 0;
  logic [NTHR-1:0] op_take_o;
  logic iss_vld_o, wr_req_o;
  logic [TW-1:0] iss_tag_o, wr_tag_o;
  logic [OPW-1:0] iss_op_o, wr_data_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mt_issue_unit #(.NTHR(NTHR), .OPW(OPW), .EXLAT(EXLAT)) uut (.*);

  bit m_bv [NTHR]; bit m_bw [NTHR]; logic [OPW-1:0] m_buf [NTHR];
  bit m_ev [EXLAT]; int m_et [EXLAT]; logic [OPW-1:0] m_ed [EXLAT];
  bit m_wv; int m_wt; logic [OPW-1:0] m_wd;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit pick(input int pct);
    return ($urandom % 100) < pct;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int t = 0; t < NTHR; t++) begin m_bv[t] = 0; m_bw[t] = 0; m_buf[t] = 0; end
    for (int i = 0; i < EXLAT; i++) begin m_ev[i] = 0; m_et[i] = 0; m_ed[i] = 0; end
    m_wv = 0; m_wt = 0; m_wd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(iss_vld_o, 0, "R1 reset issue");
    chk(wr_req_o, 0, "R1 reset write");
    chk(op_take_o, 0, "R1 reset take");
    rst_n = 1;
    @(negedge clk); #1;
    chk(op_take_o, 0, "R1 idle take");
    chk(iss_vld_o, 0, "R1 idle issue");

    for (int k = 0; k < NCYC; k++) begin
      int ph, sel;
      bit stall, ev;
      bit byp [NTHR]; bit rdy [NTHR]; bit tk [NTHR];
      @(negedge clk);
      ph = k / 1000;
      for (int t = 0; t < NTHR; t++) begin
        logic [OPW-1:0] w;
        w = OPW'($urandom);
        w[OPW-1] = ($urandom % 8) == 0;
        op_i[t*OPW +: OPW] = w;
        thr_act_i[t] = (ph == 3) ? pick(70) : pick(98);
        op_vld_i[t]  = pick(ph == 1 ? 95 : 70);
        opd_rdy_i[t] = (ph == 1) ? pick(90) : pick(35);
        br_done_i[t] = pick(20);
      end
      wr_gnt_i = (ph == 2) ? pick(20) : (ph == 1 ? 1'b1 : pick(75));
      #1;
      stall = m_wv && !wr_gnt_i;
      sel = -1;
      for (int t = 0; t < NTHR; t++) begin
        byp[t] = m_wv && wr_gnt_i && (m_wt == t);
        rdy[t] = thr_act_i[t] && m_bv[t] && (opd_rdy_i[t] || byp[t]) && !stall;
        if (rdy[t] && sel < 0) sel = t;
      end
      ev = (sel >= 0);
      for (int t = 0; t < NTHR; t++)
        tk[t] = thr_act_i[t] && op_vld_i[t] && !m_bw[t] &&
                (!m_bv[t] || (sel == t && !m_buf[t][OPW-1]));

      chk(iss_vld_o, ev, stall ? "R6 no issue in stall" : "R4 issue/nop");
      if (ev) begin
        chk(iss_tag_o, sel, (byp[sel] && !opd_rdy_i[sel]) ? "R7 bypass issue" : "R3 priority tag");
        chk(iss_op_o, m_buf[sel], "R3 issued word");
      end
      for (int t = 0; t < NTHR; t++) begin
        if (!thr_act_i[t])  chk(op_take_o[t], 0, "R9 inactive take");
        else if (m_bw[t])   chk(op_take_o[t], 0, "R8 branch wait take");
        else                chk(op_take_o[t], tk[t], "R2 fetch take");
      end
      chk(wr_req_o, m_wv, "R5 write request");
      if (m_wv) begin
        chk(wr_tag_o, m_wt, "R5 write tag");
        chk(wr_data_o, m_wd, "R5 write data");
      end

      for (int t = 0; t < NTHR; t++) begin
        if (!thr_act_i[t]) begin
          m_bv[t] = 0; m_bw[t] = 0;
        end else begin
          bit br;
          br = (sel == t) && m_buf[t][OPW-1];
          if (tk[t]) begin m_bv[t] = 1; m_buf[t] = op_i[t*OPW +: OPW]; end
          else if (sel == t) m_bv[t] = 0;
          if (br) m_bw[t] = 1;
          else if (br_done_i[t]) m_bw[t] = 0;
        end
      end
      if (!stall) begin
        m_wv = m_ev[EXLAT-1]; m_wt = m_et[EXLAT-1]; m_wd = m_ed[EXLAT-1];
        for (int i = EXLAT-1; i > 0; i--) begin
          m_ev[i] = m_ev[i-1]; m_et[i] = m_et[i-1]; m_ed[i] = m_ed[i-1];
        end
        m_ev[0] = ev;
        m_et[0] = ev ? sel : 0;
        m_ed[0] = ev ? m_buf_snap(sel) : '0;
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  logic [OPW-1:0] snap [NTHR];
  always @(negedge clk) for (int t = 0; t < NTHR; t++) snap[t] <= m_buf[t];

  function automatic logic [OPW-1:0] m_buf_snap(input int s);
    return snap[s];
  endfunction
endmodule